// File: doc/BRIEF.md
# Framebuffer Dirty Region Tracker

This block records which parts of a framebuffer have been written and turns that record into rectangles for display refresh. Each display line is 1024 bytes long, so one 4-KiB page of the indexed-colour plane holds four lines. The tracker keeps one flag per page of that plane. It also keeps one flag per page of two wide planes: a 32-bit direct-colour plane and a per-pixel control plane. Each wide plane spends four pages on the same four lines that one indexed page covers. Writers report every store with a plane code and a byte address. An invalidate pulse marks the whole screen as changed.

A frame-start pulse launches a scan. The scan looks at one group of four lines per step, from the top of the screen down. It joins neighbouring changed groups into a single run and reports each run as a full-width rectangle, given as a first line and a line count. Reports leave through a valid/ready handshake. The flags of each changed group are cleared as the scan passes it. In wide-colour mode a group counts as changed if its indexed page or any of its four pages in either wide plane is flagged.

Top module: `fb_dirty_tracker`

## Requirements
- R1: A write with plane code 0 (indexed) at byte address A flags group A>>12. A scan reports that group as line 4*(A>>12) with a count of 4.
- R2: Plane code 1 (direct colour) and plane code 2 (control) flag page A>>12 of their plane. Page P of a wide plane belongs to group P>>2. Wide-plane flags make a group changed only while mode24 is 1. While mode24 is 0 they are kept, not cleared, and they count once mode24 returns to 1.
- R3: A write with plane code 3 has no effect. A plane-0 write whose page index is GROUPS or more also has no effect.
- R4: A maximal stretch of consecutive changed groups, starting at group F and k groups long, gives exactly one report with upd_y_start = 4*F and upd_lines = 4*k. Reports come out in top-to-bottom order. Every report has a nonzero count that is a multiple of 4 and stays inside the 4*GROUPS-line screen. No report is offered while busy is low.
- R5: While upd_valid is high and upd_ready is low, the report stays valid and unchanged, and the scan does not advance.
- R6: A run that is still open at the last group is reported when the scan finishes.
- R7: The scan clears the flags of every changed group it passes. Wide-plane pages are cleared only in wide mode. A frame with no writes in between gives no reports.
- R8: A write to a group in the cycle the scan passes that group, or later, stays flagged for the next frame.
- R9: frame_start while idle raises busy on the next cycle. busy stays high until the last report of the frame is accepted. Reset leaves busy and upd_valid low.
- R10: invalidate flags every indexed page. In wide mode it also flags every page of both wide planes. In indexed mode it leaves the wide planes untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode24 | input | 1 | 1 = wide-colour mode, 0 = indexed only |
| wr_valid | input | 1 | A store into video memory happened |
| wr_plane | input | 2 | Plane code: 0 indexed, 1 direct colour, 2 control, 3 none |
| wr_addr | input | GW+14 | Byte address of the store within its plane |
| invalidate | input | 1 | Flag the whole screen |
| frame_start | input | 1 | Begin a scan (ignored while busy) |
| busy | output | 1 | Scan or final report in progress |
| upd_valid | output | 1 | Report offered |
| upd_ready | input | 1 | Report accepted when high with upd_valid |
| upd_y_start | output | LW | First line of the report |
| upd_lines | output | LW | Number of lines in the report |

## Verification
On every cycle the assertions check the shape of each report (aligned, nonzero, on screen), that a stalled report holds still, that no report appears while idle, that busy rises after a start, and that a group the scan has just cleared reads clean in indexed mode. The grouping of runs, the mapping of wide-plane pages to groups, the effect of the mode on kept flags, and the survival of a write to an already-scanned group can only be shown by the bench. It does this by sweeping every pattern of changed groups in a small screen, and every wide-plane page one at a time, and comparing the reports with runs it works out itself.

// File: rtl/fbdirty_pkg.sv
package fbdirty_pkg;
  localparam int PAGE_SHIFT      = 12;
  localparam int LINES_PER_GROUP = 4;
  localparam int WIDE_PAGES      = 4;

  typedef enum logic [1:0] {
    PLANE_IDX  = 2'd0,
    PLANE_RGB  = 2'd1,
    PLANE_CTL  = 2'd2,
    PLANE_NONE = 2'd3
  } plane_e;

  typedef enum logic [1:0] {
    SC_IDLE  = 2'd0,
    SC_WALK  = 2'd1,
    SC_DRAIN = 2'd2
  } scan_state_e;

  // first display line of a group
  function automatic int unsigned group_to_line(input int unsigned grp);
    return grp * LINES_PER_GROUP;
  endfunction

  // line count of the groups first .. past_last-1
  function automatic int unsigned run_height(input int unsigned first,
                                             input int unsigned past_last);
    return (past_last - first) * LINES_PER_GROUP;
  endfunction
endpackage

// File: rtl/fbdirty_store.sv
module fbdirty_store import fbdirty_pkg::*; #(
  parameter int GROUPS = 64,
  parameter int GW     = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode24,
  input  logic              set_valid,
  input  plane_e            set_plane,
  input  logic [GW+1:0]     set_page,
  input  logic              inval,
  input  logic              clr_valid,
  input  logic [GW-1:0]     clr_group,
  output logic [GROUPS-1:0] grp_dirty
);
  localparam int WIDE_N = WIDE_PAGES * GROUPS;

  logic [GROUPS-1:0]   idx_flags;
  logic [2*WIDE_N-1:0] wide_flags;

  // indexed plane: one flag per group
  for (genvar g = 0; g < GROUPS; g++) begin : g_idx
    logic bit_q;
    wire  hit_set = set_valid && (set_plane == PLANE_IDX) &&
                    (set_page == (GW+2)'(g));
    wire  hit_clr = clr_valid && (clr_group == GW'(g));
    always_ff @(posedge clk) begin
      if (!rst_n)                bit_q <= 1'b0;
      else if (inval || hit_set) bit_q <= 1'b1;
      else if (hit_clr)          bit_q <= 1'b0;
    end
    assign idx_flags[g] = bit_q;
  end

  // wide planes: four pages per group each
  for (genvar w = 0; w < 2; w++) begin : g_wide
    localparam plane_e PL = (w == 0) ? PLANE_RGB : PLANE_CTL;
    for (genvar p = 0; p < WIDE_N; p++) begin : g_pg
      logic bit_q;
      wire  hit_set = set_valid && (set_plane == PL) &&
                      (set_page == (GW+2)'(p));
      wire  hit_clr = clr_valid && mode24 &&
                      (clr_group == GW'(p / WIDE_PAGES));
      always_ff @(posedge clk) begin
        if (!rst_n)                            bit_q <= 1'b0;
        else if ((inval && mode24) || hit_set) bit_q <= 1'b1;
        else if (hit_clr)                      bit_q <= 1'b0;
      end
      assign wide_flags[w*WIDE_N + p] = bit_q;
    end
  end

  // per-group reduction
  for (genvar g = 0; g < GROUPS; g++) begin : g_red
    wire rgb_any = |wide_flags[g*WIDE_PAGES +: WIDE_PAGES];
    wire ctl_any = |wide_flags[WIDE_N + g*WIDE_PAGES +: WIDE_PAGES];
    assign grp_dirty[g] = idx_flags[g] | (mode24 & (rgb_any | ctl_any));
  end
endmodule

// File: rtl/fbdirty_scanner.sv
module fbdirty_scanner import fbdirty_pkg::*; #(
  parameter int GROUPS = 64,
  parameter int GW     = 6,
  parameter int LW     = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic [GROUPS-1:0] grp_dirty,
  output logic              clr_valid,
  output logic [GW-1:0]     clr_group,
  output logic              scan_step,
  output logic              run_close,
  output logic              busy,
  output logic              upd_valid,
  input  logic              upd_ready,
  output logic [LW-1:0]     upd_y_start,
  output logic [LW-1:0]     upd_lines
);
  scan_state_e   st_q;
  logic [GW-1:0] grp_q;
  logic [GW-1:0] first_q;
  logic          open_q;

  logic          slot_free;
  logic          at_last;
  logic          cur_hit;
  logic [GW-1:0] first_eff;
  int unsigned   past_i;
  logic [LW-1:0] y_next;
  logic [LW-1:0] n_next;

  always_comb begin
    slot_free = !upd_valid || upd_ready;
    scan_step = (st_q == SC_WALK) && slot_free;
    at_last   = (grp_q == GW'(GROUPS - 1));
    cur_hit   = grp_dirty[grp_q];
    first_eff = open_q ? first_q : grp_q;
    run_close = scan_step && ((open_q && !cur_hit) || (cur_hit && at_last));
    past_i    = 32'(grp_q) + (cur_hit ? 32'd1 : 32'd0);
    y_next    = LW'(group_to_line(32'(first_eff)));
    n_next    = LW'(run_height(32'(first_eff), past_i));
  end

  assign clr_valid = scan_step && cur_hit;
  assign clr_group = grp_q;
  assign busy      = (st_q != SC_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= SC_IDLE;
      grp_q   <= '0;
      first_q <= '0;
      open_q  <= 1'b0;
    end else begin
      case (st_q)
        SC_IDLE: begin
          if (frame_start) begin
            st_q   <= SC_WALK;
            grp_q  <= '0;
            open_q <= 1'b0;
          end
        end
        SC_WALK: begin
          if (scan_step) begin
            if (cur_hit && !open_q) first_q <= grp_q;
            if (at_last) begin
              st_q   <= SC_DRAIN;
              open_q <= 1'b0;
            end else begin
              grp_q  <= grp_q + 1'b1;
              open_q <= cur_hit;
            end
          end
        end
        SC_DRAIN: begin
          if (!upd_valid) st_q <= SC_IDLE;
        end
        default: st_q <= SC_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      upd_valid   <= 1'b0;
      upd_y_start <= '0;
      upd_lines   <= '0;
    end else if (run_close) begin
      upd_valid   <= 1'b1;
      upd_y_start <= y_next;
      upd_lines   <= n_next;
    end else if (upd_ready) begin
      upd_valid   <= 1'b0;
    end
  end
endmodule

// File: rtl/fb_dirty_tracker.sv
module fb_dirty_tracker import fbdirty_pkg::*; #(
  parameter  int GROUPS = 64,
  localparam int GW     = $clog2(GROUPS),
  localparam int AW     = GW + 2 + PAGE_SHIFT,
  localparam int LW     = $clog2(LINES_PER_GROUP * GROUPS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode24,
  input  logic          wr_valid,
  input  logic [1:0]    wr_plane,
  input  logic [AW-1:0] wr_addr,
  input  logic          invalidate,
  input  logic          frame_start,
  output logic          busy,
  output logic          upd_valid,
  input  logic          upd_ready,
  output logic [LW-1:0] upd_y_start,
  output logic [LW-1:0] upd_lines
);
  logic [GROUPS-1:0] grp_dirty;
  logic              clr_valid;
  logic [GW-1:0]     clr_group;
  logic              scan_step;
  logic              run_close;
  logic [GW+1:0]     wr_page;

  assign wr_page = wr_addr[AW-1:PAGE_SHIFT];

  fbdirty_store #(.GROUPS(GROUPS), .GW(GW)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode24    (mode24),
    .set_valid (wr_valid),
    .set_plane (plane_e'(wr_plane)),
    .set_page  (wr_page),
    .inval     (invalidate),
    .clr_valid (clr_valid),
    .clr_group (clr_group),
    .grp_dirty (grp_dirty)
  );

  fbdirty_scanner #(.GROUPS(GROUPS), .GW(GW), .LW(LW)) u_scan (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .grp_dirty   (grp_dirty),
    .clr_valid   (clr_valid),
    .clr_group   (clr_group),
    .scan_step   (scan_step),
    .run_close   (run_close),
    .busy        (busy),
    .upd_valid   (upd_valid),
    .upd_ready   (upd_ready),
    .upd_y_start (upd_y_start),
    .upd_lines   (upd_lines)
  );
endmodule

// File: rtl/fb_dirty_tracker_chk.sv
module fb_dirty_tracker_chk import fbdirty_pkg::*; #(
  parameter  int GROUPS = 64,
  localparam int GW     = $clog2(GROUPS),
  localparam int LW     = $clog2(LINES_PER_GROUP * GROUPS + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode24,
  input logic              wr_valid,
  input logic              invalidate,
  input logic              frame_start,
  input logic              busy,
  input logic              upd_valid,
  input logic              upd_ready,
  input logic [LW-1:0]     upd_y_start,
  input logic [LW-1:0]     upd_lines,
  input logic [GROUPS-1:0] grp_dirty,
  input logic              clr_valid,
  input logic [GW-1:0]     clr_group
);
  // R5: a stalled report holds its value
  a_r5_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !upd_ready) |=>
      (upd_valid && $stable(upd_y_start) && $stable(upd_lines)));

  // R4: report shape
  a_r4_report_shape: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |-> ((upd_lines != '0) && (upd_lines[1:0] == 2'b00) &&
                   (upd_y_start[1:0] == 2'b00) &&
                   (32'(upd_y_start) + 32'(upd_lines) <=
                    32'(LINES_PER_GROUP * GROUPS))));

  // R4: nothing offered while idle
  a_r4_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !upd_valid);

  // R9: a start while idle raises busy
  a_r9_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !busy) |=> busy);

  // R7: a group passed by the scan reads clean in indexed mode
  a_r7_group_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_valid && !wr_valid && !invalidate && !mode24) |=>
      (mode24 || !grp_dirty[$past(clr_group)]));
endmodule

bind fb_dirty_tracker fb_dirty_tracker_chk #(.GROUPS(GROUPS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mode24      (mode24),
  .wr_valid    (wr_valid),
  .invalidate  (invalidate),
  .frame_start (frame_start),
  .busy        (busy),
  .upd_valid   (upd_valid),
  .upd_ready   (upd_ready),
  .upd_y_start (upd_y_start),
  .upd_lines   (upd_lines),
  .grp_dirty   (grp_dirty),
  .clr_valid   (clr_valid),
  .clr_group   (clr_group)
);

// File: tb/sim_fb_dirty_tracker.sv
module sim_fb_dirty_tracker;
  localparam int G  = 8;
  localparam int GW = $clog2(G);
  localparam int AW = GW + 2 + 12;
  localparam int LW = $clog2(4 * G + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mode24 = 1'b0;
  logic          wr_valid = 1'b0;
  logic [1:0]    wr_plane = 2'd0;
  logic [AW-1:0] wr_addr = '0;
  logic          invalidate = 1'b0;
  logic          frame_start = 1'b0;
  logic          busy;
  logic          upd_valid;
  logic          upd_ready = 1'b1;
  logic [LW-1:0] upd_y_start;
  logic [LW-1:0] upd_lines;

  fb_dirty_tracker #(.GROUPS(G)) u0 (
    .clk(clk), .rst_n(rst_n), .mode24(mode24), .wr_valid(wr_valid),
    .wr_plane(wr_plane), .wr_addr(wr_addr), .invalidate(invalidate),
    .frame_start(frame_start), .busy(busy), .upd_valid(upd_valid),
    .upd_ready(upd_ready), .upd_y_start(upd_y_start), .upd_lines(upd_lines)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit hold   = 1'b0;
  bit stall_en = 1'b0;
  int got_cnt = 0;
  int got_y [16];
  int got_n [16];

  // ready driver and report collector
  always @(negedge clk) begin
    cyc++;
    upd_ready = hold ? 1'b0 : !(stall_en && (cyc % 3 == 0));
    if (upd_valid && upd_ready && got_cnt < 16) begin
      got_y[got_cnt] = int'(upd_y_start);
      got_n[got_cnt] = int'(upd_lines);
      got_cnt++;
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: actual cycles %0d expected below 150000", cyc);
      finish_run();
    end
  end

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic wr(input int plane, input int addr);
    @(negedge clk);
    wr_valid = 1'b1; wr_plane = 2'(plane); wr_addr = AW'(addr);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic pulse_inval();
    @(negedge clk); invalidate = 1'b1;
    @(negedge clk); invalidate = 1'b0;
  endtask

  task automatic start_frame();
    got_cnt = 0;
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
  endtask

  task automatic end_frame();
    while (busy) @(negedge clk);
  endtask

  task automatic do_frame();
    start_frame();
    end_frame();
  endtask

  // expected runs of a group mask, compared with the collected reports
  task automatic check_mask(input logic [G-1:0] m, input string rq);
    int ey [16];
    int en [16];
    int n = 0;
    int s = 0;
    bit open = 1'b0;
    for (int g = 0; g <= G; g++) begin
      bit d = (g < G) ? m[g] : 1'b0;
      if (d && !open) begin open = 1'b1; s = g; end
      else if (!d && open) begin
        open = 1'b0; ey[n] = 4 * s; en[n] = 4 * (g - s); n++;
      end
    end
    check(got_cnt == n, {rq, " report count"}, got_cnt, n);
    for (int i = 0; i < n && i < got_cnt; i++) begin
      check(got_y[i] == ey[i], {rq, " y_start"}, got_y[i], ey[i]);
      check(got_n[i] == en[i], {rq, " lines"}, got_n[i], en[i]);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9: reset state
    check(busy == 1'b0, "R9 reset busy", int'(busy), 0);
    check(upd_valid == 1'b0, "R9 reset upd_valid", int'(upd_valid), 0);

    // R1 R4 R6 R7: every indexed pattern, some with a stalling consumer
    for (int m = 0; m < (1 << G); m++) begin
      stall_en = m[0] ^ m[3];
      for (int g = 0; g < G; g++)
        if (m[g]) wr(0, g * 4096 + ((m * 37) % 4096));
      start_frame();
      if (m == 0) check(busy == 1'b1, "R9 busy after start", int'(busy), 1);
      end_frame();
      check_mask(G'(m), "R4");
    end
    stall_en = 1'b0;
    // R7: nothing left after the frame
    do_frame();
    check_mask('0, "R7");

    // R2: each wide page alone in wide mode
    mode24 = 1'b1;
    for (int g = 0; g < G; g++)
      for (int pl = 1; pl <= 2; pl++)
        for (int k = 0; k < 4; k++) begin
          wr(pl, (4 * g + k) * 4096 + 5);
          do_frame();
          check_mask(G'(1 << g), "R2");
        end
    wr(1, 9 * 4096);
    wr(2, 14 * 4096);
    wr(0, 6 * 4096);
    do_frame();
    check_mask(8'b0100_1100, "R2");

    // R2: wide flags ignored but kept in indexed mode
    mode24 = 1'b0;
    wr(1, 21 * 4096);
    do_frame();
    check_mask('0, "R2");
    mode24 = 1'b1;
    do_frame();
    check_mask(8'b0010_0000, "R2");

    // R3: plane code 3 and out-of-range indexed page
    wr(3, 0);
    wr(0, G * 4096);
    do_frame();
    check_mask('0, "R3");
    mode24 = 1'b0;
    wr(3, 4096);
    do_frame();
    check_mask('0, "R3");

    // R5 R8: stall the consumer and write an already-passed group
    hold = 1'b1;
    wr(0, 0);
    wr(0, 2 * 4096);
    start_frame();
    while (!upd_valid) @(negedge clk);
    wr(0, 100);
    begin
      int y0 = int'(upd_y_start);
      repeat (3) @(negedge clk);
      check(upd_valid == 1'b1, "R5 held valid", int'(upd_valid), 1);
      check(int'(upd_y_start) == y0, "R5 held y_start", int'(upd_y_start), y0);
      check(int'(upd_lines) == 4, "R5 held lines", int'(upd_lines), 4);
    end
    hold = 1'b0;
    end_frame();
    check_mask(8'b0000_0101, "R8");
    do_frame();
    check_mask(8'b0000_0001, "R8");

    // R10: indexed-mode invalidate leaves the wide planes alone
    pulse_inval();
    do_frame();
    check_mask(8'hFF, "R10");
    mode24 = 1'b1;
    do_frame();
    check_mask('0, "R10");
    // R10: wide-mode invalidate reaches the wide planes
    pulse_inval();
    mode24 = 1'b0;
    do_frame();
    check_mask(8'hFF, "R10");
    mode24 = 1'b1;
    do_frame();
    check_mask(8'hFF, "R10");
    do_frame();
    check_mask('0, "R10");

    finish_run();
  end
endmodule